// File: doc/BRIEF.md
# Sub-Doubleword Store Read-Merge-Write Unit

This unit sits between a store/load request port and a 64-bit tightly coupled RAM port whose contents carry one check bit per byte. A store that covers all eight bytes goes straight to the RAM. A narrower store can be handled in one of two ways. In the merge path, the unit reads the whole doubleword, splices in the strobed bytes and rewrites all eight bytes together with freshly computed check bits. In the direct path, only the strobed bytes are written and the stored check bits are left as they are. Loads go straight through to the RAM.

The choice between the two paths for narrow stores is made by an enable bit held in the unit. Software can rewrite this bit. On reset it takes its value from a tie-off input. The RAM reports faults, such as parity trouble or an address outside the attached RAM, on a single error input. The unit turns each fault into an abort. The abort is asynchronous when the failed access belongs to a store and synchronous when it belongs to a load.

The controller has five states. ST_IDLE accepts requests. ST_LOAD_RSP returns read data. ST_STORE_RSP waits for the outcome of a single write. ST_MERGE_RD receives the old doubleword and issues the write-back. ST_WB_RSP waits for the outcome of the write-back. The transitions are:

- issue_load: ST_IDLE to ST_LOAD_RSP.
- issue_write: ST_IDLE to ST_STORE_RSP, taken for a full store or a direct narrow store.
- issue_merge: ST_IDLE to ST_MERGE_RD.
- merge_fault: ST_MERGE_RD to ST_IDLE.
- write_back: ST_MERGE_RD to ST_WB_RSP.
- complete: ST_LOAD_RSP, ST_STORE_RSP or ST_WB_RSP to ST_IDLE.

Top module: `sdw_rmw_unit`

## Requirements
- R1: While reset is held, and until the first control write after it, `rmw_en` equals `rmw_tie`. After reset, `req_ready` is 1, and `ram_rd`, `ram_wr` and `abort_valid` are 0.
- R2: When `ctl_wr` is 1 at a clock edge, `rmw_en` takes the value of `ctl_wval` from the next cycle on. A store accepted at that same edge is routed by the previous value of `rmw_en`.
- R3: A store with `req_strb == 8'hFF` is issued in its accept cycle as a single write. That write has `ram_wbe == 8'hFF` and `ram_wpe == 1`, and `ram_wpar[i]` is the XOR of the byte at bits 8i+7..8i. `req_ready` is then low for exactly one cycle.
- R4: A store with any other strobe value, including 0, takes the merge path when `rmw_en` is 1:
  - In the accept cycle it reads the same address.
  - In the next cycle it writes the merged doubleword with `ram_wbe == 8'hFF` and `ram_wpe == 1`, using check bits recomputed as in R3. Byte i of the merged doubleword comes from the request when strobe bit i is 1 and from the read data otherwise.
  - `req_ready` is low for two cycles.
- R5: With `rmw_en` at 0, a narrow store is issued as a single write with `ram_wbe == req_strb` and `ram_wpe == 0`, so the stored check bits are unchanged. `req_ready` is low for one cycle.
- R6: A load issues `ram_rd` in its accept cycle. In the next cycle `rsp_valid` is 1 and `rsp_rdata` equals `ram_rdata`.
- R7: `ram_err` belongs to the access issued in the previous cycle. An error on a load raises `abort_valid` with `abort_async == 0`.
- R8: An error on the write of a store, whether a direct write or a merge write-back, raises `abort_valid` with `abort_async == 1`.
- R9: An error on the read phase of a merge cancels the write-back: no `ram_wr` is issued, an abort with `abort_async == 1` is raised, and `req_ready` returns high in the next cycle.
- R10: `req_ready` is low from the cycle after acceptance until the last response cycle of the operation, so at most one operation is in flight. `ram_rd` and `ram_wr` are never 1 together.
- R11: `ram_err` outside a response cycle is ignored: `abort_valid` is 1 only in a response cycle and only while `ram_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rmw_tie | input | 1 | Reset value of the merge enable |
| ctl_wr | input | 1 | Software write strobe for the merge enable |
| ctl_wval | input | 1 | Value written to the merge enable |
| rmw_en | output | 1 | Current merge enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Doubleword address |
| req_wdata | input | 64 | Store data |
| req_strb | input | 8 | Byte strobes of the store |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 64 | Load data |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 64 | RAM write data |
| ram_wbe | output | 8 | RAM byte write enables |
| ram_wpe | output | 1 | Check-bit write enable for the enabled bytes |
| ram_wpar | output | 8 | Check bits, one even-parity bit per byte |
| ram_rdata | input | 64 | RAM read data, one cycle after `ram_rd` |
| ram_err | input | 1 | RAM fault for the access of the previous cycle |
| abort_valid | output | 1 | Abort raised |
| abort_async | output | 1 | 1 for an asynchronous abort, 0 for a synchronous one |

## Verification
A control write to the merge enable can land on the same clock edge at which a narrow store is accepted. The bench provokes this by raising `ctl_wr` during the accept cycle, in both directions of the enable. It then judges the path taken at the RAM: it checks the busy length, whether the check bits of untouched bytes were rewritten, and the stored bytes. After that it confirms that the next narrow store follows the new setting. A second overlap is a load error, where the response and the abort share one cycle; both are checked in that cycle.

// File: rtl/sdw_rmw_pkg.sv
package sdw_rmw_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_RSP,
        ST_STORE_RSP,
        ST_MERGE_RD,
        ST_WB_RSP
    } rmw_state_e;

    typedef enum logic [1:0] {
        KIND_LOAD,
        KIND_FULL,
        KIND_MERGE,
        KIND_DIRECT
    } req_kind_e;

endpackage

// File: rtl/sdw_rmw_parity_gen.sv
module sdw_rmw_parity_gen
    import sdw_rmw_pkg::*;
#(
    parameter int LANES = 8
)
(
    input  logic [LANES*BYTE_W-1:0] data,
    output logic [LANES-1:0]        par
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign par[g] = ^data[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/sdw_rmw_byte_merge.sv
module sdw_rmw_byte_merge
    import sdw_rmw_pkg::*;
#(
    parameter int LANES = 8
)
(
    input  logic [LANES*BYTE_W-1:0] old_data,
    input  logic [LANES*BYTE_W-1:0] new_data,
    input  logic [LANES-1:0]        sel,
    output logic [LANES*BYTE_W-1:0] merged
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] = sel[g] ? new_data[g*BYTE_W +: BYTE_W]
                                                   : old_data[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/sdw_rmw_enable_reg.sv
module sdw_rmw_enable_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic tie_val,
    input  logic wr,
    input  logic wval,
    output logic en
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= tie_val;
        end else if (wr) begin
            en <= wval;
        end
    end

endmodule

// File: rtl/sdw_rmw_classify.sv
module sdw_rmw_classify
    import sdw_rmw_pkg::*;
#(
    parameter int LANES = 8
)
(
    input  logic             is_write,
    input  logic [LANES-1:0] strb,
    input  logic             merge_en,
    output req_kind_e        kind
);

    logic full;
    assign full = &strb;

    always_comb begin
        if (!is_write) begin
            kind = KIND_LOAD;
        end else if (full) begin
            kind = KIND_FULL;
        end else if (merge_en) begin
            kind = KIND_MERGE;
        end else begin
            kind = KIND_DIRECT;
        end
    end

endmodule

// File: rtl/sdw_rmw_unit.sv
module sdw_rmw_unit
    import sdw_rmw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64
)
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rmw_tie,
    input  logic                  ctl_wr,
    input  logic                  ctl_wval,
    output logic                  rmw_en,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_strb,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  ram_rd,
    output logic                  ram_wr,
    output logic [ADDR_W-1:0]     ram_addr,
    output logic [DATA_W-1:0]     ram_wdata,
    output logic [DATA_W/8-1:0]   ram_wbe,
    output logic                  ram_wpe,
    output logic [DATA_W/8-1:0]   ram_wpar,
    input  logic [DATA_W-1:0]     ram_rdata,
    input  logic                  ram_err,
    output logic                  abort_valid,
    output logic                  abort_async
);

    localparam int LANES = DATA_W / BYTE_W;

    rmw_state_e            st_q, st_d;
    req_kind_e             kind;
    logic                  accept;
    logic [ADDR_W-1:0]     cap_addr;
    logic [DATA_W-1:0]     cap_data;
    logic [LANES-1:0]      cap_strb;
    logic [DATA_W-1:0]     merged;
    logic [DATA_W-1:0]     wr_src;
    logic [LANES-1:0]      par_out;

    // Merge enable, reset from the tie-off and rewritable by software.
    sdw_rmw_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .tie_val (rmw_tie),
        .wr      (ctl_wr),
        .wval    (ctl_wval),
        .en      (rmw_en)
    );

    sdw_rmw_classify #(.LANES(LANES)) u_cls (
        .is_write (req_write),
        .strb     (req_strb),
        .merge_en (rmw_en),
        .kind     (kind)
    );

    sdw_rmw_byte_merge #(.LANES(LANES)) u_merge (
        .old_data (ram_rdata),
        .new_data (cap_data),
        .sel      (cap_strb),
        .merged   (merged)
    );

    assign wr_src = (st_q == ST_MERGE_RD) ? merged : req_wdata;

    sdw_rmw_parity_gen #(.LANES(LANES)) u_par (
        .data (wr_src),
        .par  (par_out)
    );

    assign accept    = req_valid && (st_q == ST_IDLE);
    assign rsp_rdata = ram_rdata;
    assign ram_wdata = wr_src;
    assign ram_wpar  = par_out;

    // Capture of the pending merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_strb <= '0;
        end else if (accept && kind == KIND_MERGE) begin
            cap_addr <= req_addr;
            cap_data <= req_wdata;
            cap_strb <= req_strb;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (kind)
                        KIND_LOAD:   st_d = ST_LOAD_RSP;
                        KIND_MERGE:  st_d = ST_MERGE_RD;
                        KIND_FULL,
                        KIND_DIRECT: st_d = ST_STORE_RSP;
                        default:     st_d = ST_IDLE;
                    endcase
                end
            end
            ST_MERGE_RD: st_d = ram_err ? ST_IDLE : ST_WB_RSP;
            ST_LOAD_RSP,
            ST_STORE_RSP,
            ST_WB_RSP:   st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        ram_rd      = 1'b0;
        ram_wr      = 1'b0;
        ram_addr    = req_addr;
        ram_wbe     = '0;
        ram_wpe     = 1'b0;
        abort_valid = 1'b0;
        abort_async = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    unique case (kind)
                        KIND_LOAD,
                        KIND_MERGE: ram_rd = 1'b1;
                        KIND_FULL: begin
                            ram_wr  = 1'b1;
                            ram_wbe = '1;
                            ram_wpe = 1'b1;
                        end
                        KIND_DIRECT: begin
                            ram_wr  = 1'b1;
                            ram_wbe = req_strb;
                            ram_wpe = 1'b0;
                        end
                        default: ram_rd = 1'b0;
                    endcase
                end
            end
            ST_LOAD_RSP: begin
                rsp_valid   = 1'b1;
                abort_valid = ram_err;
            end
            ST_STORE_RSP,
            ST_WB_RSP: begin
                abort_valid = ram_err;
                abort_async = ram_err;
            end
            ST_MERGE_RD: begin
                ram_addr = cap_addr;
                if (ram_err) begin
                    abort_valid = 1'b1;
                    abort_async = 1'b1;
                end else begin
                    ram_wr  = 1'b1;
                    ram_wbe = '1;
                    ram_wpe = 1'b1;
                end
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdw_rmw_checker.sv
module sdw_rmw_checker #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 64
)
(
    input logic                clk,
    input logic                rst_n,
    input logic                rmw_tie,
    input logic                rmw_en,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic [DATA_W/8-1:0] req_strb,
    input logic                ram_rd,
    input logic                ram_wr,
    input logic [DATA_W-1:0]   ram_wdata,
    input logic [DATA_W/8-1:0] ram_wbe,
    input logic                ram_wpe,
    input logic [DATA_W/8-1:0] ram_wpar,
    input logic                ram_err,
    input logic                abort_valid,
    input logic                abort_async
);

    localparam int LANES = DATA_W / 8;

    logic             acc;
    logic             narrow;
    logic [LANES-1:0] ref_par;

    assign acc    = req_valid && req_ready;
    assign narrow = req_write && !(&req_strb);

    for (genvar g = 0; g < LANES; g++) begin : g_ref
        assign ref_par[g] = ^ram_wdata[g*8 +: 8];
    end

    assert_reset_en_R1: assert property (@(posedge clk) !rst_n |=> rmw_en == $past(rmw_tie));

    assert_full_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && (&req_strb)) |-> (ram_wr && !ram_rd && (&ram_wbe) && ram_wpe));

    assert_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_wr && ram_wpe) |-> (ram_wpar == ref_par));

    assert_merge_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && narrow && rmw_en) |-> (ram_rd && !ram_wr));

    assert_direct_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && narrow && !rmw_en) |-> (ram_wr && ram_wbe == req_strb && !ram_wpe));

    assert_load_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc && !req_write) && ram_err) |-> (abort_valid && !abort_async));

    assert_store_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ram_wr) && ram_err) |-> (abort_valid && abort_async));

    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc && narrow && rmw_en) && ram_err) |-> (!ram_wr && abort_valid && abort_async));

    assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready);

    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd && ram_wr));

    assert_abort_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |-> (ram_err && !req_ready));

endmodule

bind sdw_rmw_unit sdw_rmw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rmw_tie     (rmw_tie),
    .rmw_en      (rmw_en),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_strb    (req_strb),
    .ram_rd      (ram_rd),
    .ram_wr      (ram_wr),
    .ram_wdata   (ram_wdata),
    .ram_wbe     (ram_wbe),
    .ram_wpe     (ram_wpe),
    .ram_wpar    (ram_wpar),
    .ram_err     (ram_err),
    .abort_valid (abort_valid),
    .abort_async (abort_async)
);

// File: tb/sdw_rmw_unit_tb.sv
`timescale 1ns/1ps
module sdw_rmw_unit_tb;

    localparam int AW    = 5;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rmw_tie = 1'b1;
    logic        ctl_wr = 1'b0;
    logic        ctl_wval = 1'b0;
    logic        rmw_en;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_strb = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        ram_rd, ram_wr, ram_wpe;
    logic [AW-1:0] ram_addr;
    logic [63:0] ram_wdata;
    logic [7:0]  ram_wbe, ram_wpar;
    logic [63:0] ram_rdata;
    logic        ram_err;
    logic        abort_valid, abort_async;

    logic        err_q;
    logic        stray_err = 1'b0;
    logic        wr_fault = 1'b0;
    logic [63:0] mem [DEPTH];
    logic [7:0]  par [DEPTH];
    logic [63:0] exp_mem [DEPTH];
    logic [7:0]  exp_par [DEPTH];

    int n_chk = 0;
    int n_fail = 0;
    int o_busy;
    logic o_abort, o_async, o_rsp;
    logic [63:0] o_rdata;

    always #2.5 clk = ~clk;

    sdw_rmw_unit #(.ADDR_W(AW), .DATA_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .rmw_tie(rmw_tie), .ctl_wr(ctl_wr), .ctl_wval(ctl_wval),
        .rmw_en(rmw_en), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_wbe(ram_wbe), .ram_wpe(ram_wpe), .ram_wpar(ram_wpar),
        .ram_rdata(ram_rdata), .ram_err(ram_err), .abort_valid(abort_valid),
        .abort_async(abort_async)
    );

    function automatic logic [63:0] init_word(input int i);
        return 64'hA5A5_0F0F_3C3C_9696 + 64'(i) * 64'h0101_0203_0405_0607;
    endfunction

    function automatic logic [7:0] pgen(input logic [63:0] d);
        logic [7:0] p;
        for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8];
        return p;
    endfunction

    function automatic logic [63:0] bmerge(input logic [63:0] o, input logic [63:0] n,
                                           input logic [7:0] s);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = s[b] ? n[b*8 +: 8] : o[b*8 +: 8];
        return r;
    endfunction

    // RAM model: one-cycle read latency, error for addresses past DEPTH.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= init_word(i);
                par[i] <= pgen(init_word(i));
            end
            ram_rdata <= '0;
            err_q     <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (ram_rd) begin
                ram_rdata <= (int'(ram_addr) < DEPTH) ? mem[ram_addr[3:0]] : 64'h0;
                err_q     <= int'(ram_addr) >= DEPTH;
            end
            if (ram_wr) begin
                if (int'(ram_addr) < DEPTH && !wr_fault) begin
                    for (int b = 0; b < 8; b++) begin
                        if (ram_wbe[b]) mem[ram_addr[3:0]][b*8 +: 8] <= ram_wdata[b*8 +: 8];
                        if (ram_wbe[b] && ram_wpe) par[ram_addr[3:0]][b] <= ram_wpar[b];
                    end
                end
                err_q <= (int'(ram_addr) >= DEPTH) || wr_fault;
            end
        end
    end
    assign ram_err = err_q | stray_err;

    task automatic check(input logic ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic init_exp();
        for (int i = 0; i < DEPTH; i++) begin
            exp_mem[i] = init_word(i);
            exp_par[i] = pgen(init_word(i));
        end
    endtask

    task automatic do_reset(input logic tie);
        @(negedge clk);
        rst_n = 1'b0;
        rmw_tie = tie;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        init_exp();
        @(negedge clk);
    endtask

    // One request; outputs sampled at negedges until ready returns high.
    task automatic run_op(input logic w, input logic [AW-1:0] a, input logic [63:0] d,
                          input logic [7:0] s, input logic cpulse, input logic cval);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_strb = s;
        ctl_wr = cpulse; ctl_wval = cval;
        @(negedge clk);
        req_valid = 1'b0; ctl_wr = 1'b0;
        o_busy = 0; o_abort = 1'b0; o_async = 1'b0; o_rsp = 1'b0; o_rdata = '0;
        while (!req_ready && o_busy < 20) begin
            o_busy++;
            if (abort_valid) begin o_abort = 1'b1; o_async = abort_async; end
            if (rsp_valid) begin o_rsp = 1'b1; o_rdata = rsp_rdata; end
            @(negedge clk);
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wval = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        check(rmw_en == v, "R2 enable write", 64'(rmw_en), 64'(v));
    endtask

    // Store in range with expected values from the requirements.
    task automatic store_and_check(input logic [3:0] a, input logic [63:0] d,
                                   input logic [7:0] s, input logic en_used,
                                   input logic cpulse, input logic cval);
        logic [63:0] m;
        int eb;
        if (s == 8'hFF) begin
            m = d; exp_par[a] = pgen(d); eb = 1;
        end else if (en_used) begin
            m = bmerge(exp_mem[a], d, s); exp_par[a] = pgen(m); eb = 2;
        end else begin
            m = bmerge(exp_mem[a], d, s); eb = 1;
        end
        exp_mem[a] = m;
        run_op(1'b1, {1'b0, a}, d, s, cpulse, cval);
        check(mem[a] == exp_mem[a], (s == 8'hFF) ? "R3 data" : (en_used ? "R4 data" : "R5 data"),
              mem[a], exp_mem[a]);
        check(par[a] == exp_par[a], (s == 8'hFF) ? "R3 check bits" :
              (en_used ? "R4 check bits" : "R5 check bits"), 64'(par[a]), 64'(exp_par[a]));
        check(o_busy == eb, "R10 busy length", 64'(o_busy), 64'(eb));
        check(!o_abort, "R8 no abort", 64'(o_abort), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1 with tie-off high
        do_reset(1'b1);
        check(rmw_en == 1'b1, "R1 enable from tie", 64'(rmw_en), 64'd1);
        check(req_ready && !ram_rd && !ram_wr && !abort_valid, "R1 idle outputs",
              {60'd0, req_ready, ram_rd, ram_wr, abort_valid}, 64'h8);

        // R3 R4 R5: sweep all strobe values with enable off then on
        for (int en = 0; en < 2; en++) begin
            set_en(en[0]);
            for (int s = 0; s < 256; s++) begin
                store_and_check(4'(s + en * 7), 64'h9E37_79B9_7F4A_7C15 * 64'(s + 1 + en * 300),
                                8'(s), en[0], 1'b0, 1'b0);
            end
        end

        // R6: loads of every entry
        for (int a = 0; a < DEPTH; a++) begin
            run_op(1'b0, 5'(a), 64'h0, 8'h0, 1'b0, 1'b0);
            check(o_rsp && o_rdata == exp_mem[a], "R6 load data", o_rdata, exp_mem[a]);
            check(o_busy == 1 && !o_abort, "R6 load busy", 64'(o_busy), 64'd1);
        end

        // R7: load error, response and abort in the same cycle
        run_op(1'b0, 5'd20, 64'h0, 8'h0, 1'b0, 1'b0);
        check(o_rsp && o_abort && !o_async, "R7 sync abort on load",
              {61'd0, o_rsp, o_abort, o_async}, 64'h6);

        // R8: error on a full store and on a direct narrow store
        run_op(1'b1, 5'd17, 64'h1234, 8'hFF, 1'b0, 1'b0);
        check(o_abort && o_async, "R8 async abort full store", {62'd0, o_abort, o_async}, 64'h3);
        set_en(1'b0);
        run_op(1'b1, 5'd30, 64'h1234, 8'h0F, 1'b0, 1'b0);
        check(o_abort && o_async && o_busy == 1, "R8 async abort direct store",
              {62'd0, o_abort, o_async}, 64'h3);

        // R9: read-phase error cancels the write-back
        set_en(1'b1);
        run_op(1'b1, 5'd25, 64'h5555, 8'h03, 1'b0, 1'b0);
        check(o_abort && o_async, "R9 async abort on merge read", {62'd0, o_abort, o_async}, 64'h3);
        check(o_busy == 1, "R9 write cancelled, ready back", 64'(o_busy), 64'd1);

        // R8: error on the write-back of a merge
        wr_fault = 1'b1;
        run_op(1'b1, 5'd3, 64'hFFFF_0000, 8'h30, 1'b0, 1'b0);
        wr_fault = 1'b0;
        check(o_abort && o_async && o_busy == 2, "R8 async abort on write-back",
              {62'd0, o_abort, o_async}, 64'h3);
        check(mem[3] == exp_mem[3], "R8 faulted write dropped", mem[3], exp_mem[3]);

        // R11: stray error while idle
        @(negedge clk);
        stray_err = 1'b1;
        @(negedge clk);
        check(!abort_valid && req_ready, "R11 stray error ignored", 64'(abort_valid), 64'd0);
        stray_err = 1'b0;
        store_and_check(4'd5, 64'hDEAD_BEEF_0BAD_F00D, 8'h81, 1'b1, 1'b0, 1'b0);

        // R2: enable write in the accept cycle of a narrow store, both directions
        store_and_check(4'd6, 64'h0102_0304_0506_0708, 8'h11, 1'b1, 1'b1, 1'b0);
        check(rmw_en == 1'b0, "R2 enable now off", 64'(rmw_en), 64'd0);
        store_and_check(4'd7, 64'h7F7F_7F7F_0101_0101, 8'h0F, 1'b0, 1'b0, 1'b0);
        store_and_check(4'd8, 64'h8000_0001_8000_0001, 8'hF0, 1'b0, 1'b1, 1'b1);
        check(rmw_en == 1'b1, "R2 enable now on", 64'(rmw_en), 64'd1);
        store_and_check(4'd9, 64'h0303_0303_0303_0303, 8'h66, 1'b1, 1'b0, 1'b0);

        // R1 with tie-off low: narrow store goes direct
        do_reset(1'b0);
        check(rmw_en == 1'b0, "R1 enable from tie low", 64'(rmw_en), 64'd0);
        store_and_check(4'd2, 64'h0101_0101_0101_0101, 8'h01, 1'b0, 1'b0, 1'b0);

        summary();
        $finish;
    end

endmodule